// File: doc/BRIEF.md
# Coprocessor Enable Register with Change-Triggered Flush

This block holds one control register that decides, bit by bit, which of coprocessors 0 to 13 are enabled. Software reaches it through a small access port that carries a four-field system-register address, a privilege level, a write strobe with data, and a read strobe with returned data. Each stored bit drives one enable output. Downstream decode logic uses these outputs to decide how later coprocessor instructions are handled.

Changing the register changes how later instructions decode, so anything already fetched or translated under the old setting is stale. The block therefore raises a one-cycle flush request, but only when a write actually alters the stored value. Rewriting the value already held costs nothing. The register answers at a single address and only for privileged callers. Any other access reads as zero, has no effect, and is flagged as a fault in the same cycle.

Top module: `cp_enable_reg`

## Requirements
- R1: Only write data bits 13:0 are stored, one bit per coprocessor; bits 31:14 of a write are dropped and have no effect on the stored value.
- R2: A synchronous active-high reset clears the stored value to zero and holds `flush_req` low.
- R3: An accepted write whose bits 13:0 equal the stored value leaves the register unchanged and produces no flush pulse.
- R4: An accepted write whose bits 13:0 differ from the stored value updates the register at that clock edge. `flush_req` is high for exactly the one cycle that follows that edge.
- R5: Accesses are accepted only at crn=15, crm=1, opc1=0, opc2=0. At any other address a write changes nothing, a read returns zero, and `acc_fault` is high while the strobe is high.
- R6: `priv_lvl` is coded 0 to 3; level 0 is unprivileged. A level-0 access is refused (no write, read data zero, `acc_fault` high), while levels 1, 2 and 3 are accepted.
- R7: An accepted read returns the stored 14 bits in bits 13:0, with bits 31:14 zero, combinationally in the same cycle as the strobe. With no accepted read, `rd_data` is zero.
- R8: `cp_en[i]` equals stored bit i (coprocessor i) and takes a new value at the same edge as the register.
- R9: Changing writes on consecutive cycles each produce their own flush cycle, so `flush_req` stays high for one cycle per changing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| crn | input | 4 | Primary register number of the access |
| crm | input | 4 | Secondary register number of the access |
| opc1 | input | 3 | First opcode field of the access |
| opc2 | input | 3 | Second opcode field of the access |
| priv_lvl | input | 2 | Privilege level of the caller, 0 = unprivileged |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| acc_fault | output | 1 | Strobed access refused (wrong address or privilege) |
| flush_req | output | 1 | One-cycle flush request after a changing write |
| cp_en | output | 14 | Enable per coprocessor, bit i for coprocessor i |

## Verification
Read data and the fault flag are combinational, so the bench samples them shortly after it drives the strobe, in the same cycle. A write takes effect at the next rising edge. `cp_en` and `flush_req` are therefore both due in the cycle that begins at that edge, and the bench samples them at the falling edge that follows. One cycle later it samples again to confirm that the flush pulse has dropped. All inputs change on falling edges, so every sample falls between edges.

// File: rtl/cp_enable_pkg.sv
package cp_enable_pkg;

    localparam int CP_COUNT = 14;
    localparam int XLEN     = 32;

    typedef struct packed {
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] opc1;
        logic [2:0] opc2;
    } sysreg_addr_t;

    localparam sysreg_addr_t CPEN_ADDR = '{crn: 4'd15, crm: 4'd1, opc1: 3'd0, opc2: 3'd0};

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_K1   = 2'd1,
        PRIV_K2   = 2'd2,
        PRIV_K3   = 2'd3
    } priv_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic fault;
    } acc_grant_t;

    function automatic logic priv_allows(priv_t p);
        return p != PRIV_USER;
    endfunction

    function automatic logic addr_match(sysreg_addr_t a, sysreg_addr_t ref_a);
        return (a.crn == ref_a.crn) && (a.crm == ref_a.crm) &&
               (a.opc1 == ref_a.opc1) && (a.opc2 == ref_a.opc2);
    endfunction

endpackage

// File: rtl/cp_enable_decode.sv
module cp_enable_decode
    import cp_enable_pkg::*;
#(
    parameter sysreg_addr_t MY_ADDR = CPEN_ADDR
) (
    input  sysreg_addr_t addr,
    input  priv_t        priv,
    input  logic         wr_en,
    input  logic         rd_en,
    output acc_grant_t   grant
);
    logic allowed;

    always_comb begin
        allowed     = addr_match(addr, MY_ADDR) && priv_allows(priv);
        grant.wr_ok = wr_en && allowed;
        grant.rd_ok = rd_en && allowed;
        grant.fault = (wr_en || rd_en) && !allowed;
    end

    always_comb begin
        if (grant.wr_ok || grant.rd_ok) begin
            a_priv_r6: assert (priv != PRIV_USER);
        end
    end

endmodule

// File: rtl/cp_enable_store.sv
module cp_enable_store #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ok,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] q,
    output logic         flush
);
    logic changes;

    always_comb changes = wr_ok && (wr_bits != q);

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            flush <= 1'b0;
        end else begin
            flush <= changes;
            if (changes) q <= wr_bits;
        end
    end

    p_reset_clear_r2: assert property (@(posedge clk) rst |=> (q == '0 && !flush));

    p_same_no_flush_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_bits == q) |=> (!flush && $stable(q)));

    p_flush_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        flush |-> ($past(wr_ok) && q != $past(q)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> ($stable(q) && !flush));

endmodule

// File: rtl/cp_enable_reg.sv
module cp_enable_reg
    import cp_enable_pkg::*;
#(
    parameter int NCP = CP_COUNT,
    parameter int DW  = XLEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     crn,
    input  logic [3:0]     crm,
    input  logic [2:0]     opc1,
    input  logic [2:0]     opc2,
    input  logic [1:0]     priv_lvl,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_data,
    output logic           acc_fault,
    output logic           flush_req,
    output logic [NCP-1:0] cp_en
);
    localparam int PAD = DW - NCP;

    sysreg_addr_t addr;
    acc_grant_t   grant;
    logic [NCP-1:0] stored;

    always_comb addr = '{crn: crn, crm: crm, opc1: opc1, opc2: opc2};

    cp_enable_decode #(.MY_ADDR(CPEN_ADDR)) u_dec (
        .addr  (addr),
        .priv  (priv_t'(priv_lvl)),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .grant (grant)
    );

    cp_enable_store #(.W(NCP)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (grant.wr_ok),
        .wr_bits (wr_data[NCP-1:0]),
        .q       (stored),
        .flush   (flush_req)
    );

    generate
        if (PAD > 0) begin : g_pad
            always_comb rd_data = grant.rd_ok ? {{PAD{1'b0}}, stored} : '0;
        end else begin : g_nopad
            always_comb rd_data = grant.rd_ok ? stored[DW-1:0] : '0;
        end
    endgenerate

    always_comb acc_fault = grant.fault;

    for (genvar i = 0; i < NCP; i++) begin : g_en
        always_comb cp_en[i] = stored[i];
    end

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data >> NCP) == '0);

    p_fault_excl_r5: assert property (@(posedge clk) disable iff (rst)
        acc_fault |-> rd_data == '0);

    p_flush_follows_r4: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> cp_en != $past(cp_en));

endmodule

// File: tb/cp_enable_reg_bench.sv
module cp_enable_reg_bench;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic [3:0]  crn, crm;
    logic [2:0]  opc1, opc2;
    logic [1:0]  priv_lvl;
    logic        wr_en, rd_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        acc_fault, flush_req;
    logic [13:0] cp_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    cp_enable_reg u_cp_enable_reg (
        .clk(clk), .rst(rst), .crn(crn), .crm(crm), .opc1(opc1), .opc2(opc2),
        .priv_lvl(priv_lvl), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .acc_fault(acc_fault), .flush_req(flush_req), .cp_en(cp_en)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_addr(logic [3:0] n, logic [3:0] m, logic [2:0] o1, logic [2:0] o2);
        crn = n; crm = m; opc1 = o1; opc2 = o2;
    endtask

    // write at current address; returns after the edge, at a falling edge
    task automatic do_write(logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic read_now(output logic [31:0] v, output logic f);
        @(negedge clk);
        rd_en = 1;
        #1;
        v = rd_data; f = acc_fault;
        rd_en = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v; logic f;
        chk("R2 cp_en after reset", 32'(cp_en), 0);
        chk("R2 flush after reset", 32'(flush_req), 0);
        read_now(v, f);
        chk("R2 read after reset", v, 0);
    endtask

    task automatic t_change;
        logic [31:0] v; logic f;
        do_write(32'h0000_2A5B);
        chk("R4 flush high after change", 32'(flush_req), 1);
        chk("R8 cp_en updated", 32'(cp_en), 32'h2A5B);
        @(negedge clk);
        chk("R4 flush drops", 32'(flush_req), 0);
        read_now(v, f);
        chk("R7 read value", v, 32'h0000_2A5B);
        chk("R7 no fault", 32'(f), 0);
    endtask

    task automatic t_same;
        do_write(32'h0000_2A5B);
        chk("R3 no flush on equal write", 32'(flush_req), 0);
        chk("R3 value held", 32'(cp_en), 32'h2A5B);
    endtask

    task automatic t_upper;
        logic [31:0] v; logic f;
        do_write(32'hFFFF_C000 | 32'h2A5B);
        chk("R1 upper bits no flush", 32'(flush_req), 0);
        do_write(32'hABCD_0001);
        chk("R1 low bits kept", 32'(cp_en), 32'h0001);
        read_now(v, f);
        chk("R1 read zero-extended", v, 32'h0000_0001);
    endtask

    task automatic t_enable_map;
        for (int i = 0; i < 14; i++) begin
            do_write(32'h1 << i);
            chk("R8 single enable bit", 32'(cp_en), 32'h1 << i);
        end
    endtask

    task automatic t_addr_miss;
        logic [31:0] v; logic f;
        do_write(32'h0000_0003);
        set_addr(4'd15, 4'd0, 3'd0, 3'd0); do_write(32'h3FFF);
        chk("R5 crm miss ignored", 32'(cp_en), 3);
        chk("R5 crm miss no flush", 32'(flush_req), 0);
        read_now(v, f);
        chk("R5 miss read zero", v, 0);
        chk("R5 miss fault", 32'(f), 1);
        set_addr(4'd14, 4'd1, 3'd0, 3'd0); do_write(32'h3FFF);
        chk("R5 crn miss ignored", 32'(cp_en), 3);
        set_addr(4'd15, 4'd1, 3'd1, 3'd0); do_write(32'h3FFF);
        chk("R5 opc1 miss ignored", 32'(cp_en), 3);
        set_addr(4'd15, 4'd1, 3'd0, 3'd4); do_write(32'h3FFF);
        chk("R5 opc2 miss ignored", 32'(cp_en), 3);
        set_addr(4'd15, 4'd1, 3'd0, 3'd0);
        read_now(v, f);
        chk("R5 hit read intact", v, 3);
    endtask

    task automatic t_priv;
        logic [31:0] v; logic f;
        priv_lvl = 0;
        do_write(32'h1000);
        chk("R6 user write ignored", 32'(cp_en), 3);
        read_now(v, f);
        chk("R6 user read zero", v, 0);
        chk("R6 user fault", 32'(f), 1);
        priv_lvl = 3;
        do_write(32'h1000);
        chk("R6 level3 write", 32'(cp_en), 32'h1000);
        priv_lvl = 2;
        read_now(v, f);
        chk("R6 level2 read", v, 32'h1000);
        priv_lvl = 1;
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        wr_en = 1; wr_data = 32'h0011;
        @(negedge clk);
        chk("R9 first flush", 32'(flush_req), 1);
        chk("R9 first value", 32'(cp_en), 32'h0011);
        wr_data = 32'h0022;
        @(negedge clk);
        wr_en = 0;
        chk("R9 second flush", 32'(flush_req), 1);
        chk("R9 second value", 32'(cp_en), 32'h0022);
        @(negedge clk);
        chk("R9 flush ends", 32'(flush_req), 0);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R2 reset clears value", 32'(cp_en), 0);
        chk("R2 reset flush low", 32'(flush_req), 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; wr_data = '0; priv_lvl = 1;
        set_addr(4'd15, 4'd1, 3'd0, 3'd0);
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_change();
        t_same();
        t_upper();
        t_enable_map();
        t_addr_miss();
        t_priv();
        t_back_to_back();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule